// File: doc/BRIEF.md
# Local Interrupt Vector Dispatcher

The dispatcher turns local interrupt events into processor interrupt signals. There are three sources: a timer expiry and two local interrupt pins, pin A and pin B. Each source has its own vector entry. An entry holds a mask flag, a level flag, a 3-bit delivery mode and an 8-bit vector. When a source fires and its entry is unmasked, the mode picks what happens. The event can become a one-cycle system-management pulse, a non-maskable pulse or an external hard-interrupt pulse. In fixed mode it instead sets one bit of a 256-bit request register, and the matching bit of a 256-bit trigger-mode register records whether the delivery was level or edge.

A legacy interrupt-controller request does not have a path of its own. It is routed through the pin A entry, and it is admitted only when the processor id is zero and either the global enable is low or the pin A entry is unmasked. Entries are loaded through a single-cycle write port that selects an entry by address: the timer at 0, pin A at 3 and pin B at 4. All outputs are registered, so a result appears one cycle after the event that caused it.

Top module: `lvec_dispatch`

## Requirements
- R1: After reset every entry is masked, the three pulse outputs are low, and both 256-bit registers read zero.
- R2: A write with `wr_en` high loads the entry at address 0 (timer), 3 (pin A) or 4 (pin B). A write to any other address changes no entry. An event in the same cycle as a write is decoded with the entry's previous contents.
- R3: An event whose entry has the mask flag set produces no pulse and changes neither register.
- R4: An unmasked event in mode 3'b010 raises `smi_pulse`, mode 3'b100 raises `nmi_pulse`, and mode 3'b111 raises `ext_pulse`. Each pulse appears in the cycle after the event and lasts exactly one cycle.
- R5: An unmasked event in mode 3'b000 sets bit `vector` of `req_vec` in the cycle after the event. Request bits stay set until reset.
- R6: On a fixed delivery, the trigger bit for that vector becomes 1 when the source is pin A or pin B and its level flag is set. Otherwise it becomes 0. A timer delivery is always recorded as edge (0).
- R7: Modes 3'b001, 3'b011, 3'b101 and 3'b110 produce no pulse and change neither register.
- R8: `legacy_req` acts as a pin A event only when `cpu_id` is 0 and either `glob_en` is low or the pin A entry is unmasked. Even when it is admitted, a masked pin A entry still drops it.
- R9: Sources that fire in the same cycle are decoded independently, and their pulses and request bits appear together. If several fixed deliveries hit one vector in the same cycle, the trigger bit becomes 1 if any of them is level.
- R10: In a cycle with no event, the next cycle has all pulses low and both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 3 | Entry address (0 timer, 3 pin A, 4 pin B) |
| wr_mask | input | 1 | Mask flag for the written entry |
| wr_level | input | 1 | Level flag for the written entry |
| wr_mode | input | 3 | Delivery mode for the written entry |
| wr_vector | input | 8 | Vector number for the written entry |
| timer_evt | input | 1 | Timer expiry event, one cycle |
| pina_evt | input | 1 | Pin A event |
| pinb_evt | input | 1 | Pin B event |
| legacy_req | input | 1 | Legacy interrupt-controller request |
| cpu_id | input | 8 | Processor id |
| glob_en | input | 1 | Global enable of the local controller |
| smi_pulse | output | 1 | System-management interrupt pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| ext_pulse | output | 1 | External hard-interrupt pulse |
| req_vec | output | 256 | Fixed-vector request bits |
| trig_vec | output | 256 | Trigger mode per vector (1 level, 0 edge) |

## Verification
The assertions assume that reset is low from time zero and that events are sampled once per cycle as single-cycle strobes. They also assume that nothing outside the block clears the request register, because this block has no clear path. Under those conditions request bits can only grow, trigger bits stay within the request bits, and a quiet cycle leaves everything still. The stimulus holds each event and write for exactly one cycle between falling edges. It uses only the three valid entry addresses plus deliberately chosen unused ones, and it spreads modes across all eight codes, so that the reserved encodings and the legacy gating conditions come up often.

// File: rtl/lvec_dispatch.sv
module lvec_dispatch #(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 3,
  parameter int ID_W   = 8,
  localparam int NVEC  = 1 << VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_mask,
  input  logic              wr_level,
  input  logic [2:0]        wr_mode,
  input  logic [VEC_W-1:0]  wr_vector,
  input  logic              timer_evt,
  input  logic              pina_evt,
  input  logic              pinb_evt,
  input  logic              legacy_req,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic              glob_en,
  output logic              smi_pulse,
  output logic              nmi_pulse,
  output logic              ext_pulse,
  output logic [NVEC-1:0]   req_vec,
  output logic [NVEC-1:0]   trig_vec
);
  localparam int NSRC  = 3;
  localparam int S_TMR = 0;
  localparam int S_PA  = 1;
  localparam logic [2:0] M_FIXED = 3'b000;
  localparam logic [2:0] M_SMI   = 3'b010;
  localparam logic [2:0] M_NMI   = 3'b100;
  localparam logic [2:0] M_EXT   = 3'b111;

  logic             e_mask [NSRC];
  logic             e_lvl  [NSRC];
  logic [2:0]       e_mode [NSRC];
  logic [VEC_W-1:0] e_vec  [NSRC];
  logic [NSRC-1:0]  evt, fire;
  logic             legacy_ok;
  logic             smi_n, nmi_n, ext_n;
  logic [NVEC-1:0]  set_n, lvl_n;

  assign legacy_ok = legacy_req && (cpu_id == '0) && (!glob_en || !e_mask[S_PA]);
  assign evt = {pinb_evt, pina_evt | legacy_ok, timer_evt};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [ADDR_W-1:0] ADDR = (g == 0) ? ADDR_W'(0) : (g == 1) ? ADDR_W'(3) : ADDR_W'(4);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_mask[g] <= 1'b1;
        e_lvl[g]  <= 1'b0;
        e_mode[g] <= M_FIXED;
        e_vec[g]  <= '0;
      end else if (wr_en && wr_addr == ADDR) begin
        e_mask[g] <= wr_mask;
        e_lvl[g]  <= wr_level;
        e_mode[g] <= wr_mode;
        e_vec[g]  <= wr_vector;
      end
    end
    assign fire[g] = evt[g] & ~e_mask[g];
  end

  always_comb begin
    smi_n = 1'b0;
    nmi_n = 1'b0;
    ext_n = 1'b0;
    set_n = '0;
    lvl_n = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (fire[s]) begin
        case (e_mode[s])
          M_SMI: smi_n = 1'b1;
          M_NMI: nmi_n = 1'b1;
          M_EXT: ext_n = 1'b1;
          M_FIXED: begin
            set_n[e_vec[s]] = 1'b1;
            if (s != S_TMR && e_lvl[s]) lvl_n[e_vec[s]] = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_pulse <= 1'b0;
      nmi_pulse <= 1'b0;
      ext_pulse <= 1'b0;
      req_vec   <= '0;
      trig_vec  <= '0;
    end else begin
      smi_pulse <= smi_n;
      nmi_pulse <= nmi_n;
      ext_pulse <= ext_n;
      req_vec   <= req_vec | set_n;
      trig_vec  <= (trig_vec & ~set_n) | lvl_n;
    end
  end
endmodule

// File: rtl/lvec_dispatch_chk.sv
module lvec_dispatch_chk #(
  parameter int NVEC = 256,
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            timer_evt,
  input logic            pina_evt,
  input logic            pinb_evt,
  input logic            legacy_req,
  input logic [ID_W-1:0] cpu_id,
  input logic            smi_pulse,
  input logic            nmi_pulse,
  input logic            ext_pulse,
  input logic [NVEC-1:0] req_vec,
  input logic [NVEC-1:0] trig_vec
);
  logic quiet;
  assign quiet = !timer_evt && !pina_evt && !pinb_evt && !legacy_req;

  assert_req_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_vec & $past(req_vec)) == $past(req_vec)));

  assert_trig_in_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_vec & ~req_vec) == '0);

  assert_quiet_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (!smi_pulse && !nmi_pulse && !ext_pulse));

  assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ($stable(req_vec) && $stable(trig_vec)));

  assert_legacy_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_req && cpu_id != '0 && !timer_evt && !pina_evt && !pinb_evt)
      |=> (!smi_pulse && !nmi_pulse && !ext_pulse && $stable(req_vec)));

  assert_timer_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_evt && !pina_evt && !pinb_evt && !legacy_req)
      |=> ((req_vec & ~$past(req_vec) & trig_vec) == '0));
endmodule

bind lvec_dispatch lvec_dispatch_chk #(.NVEC(NVEC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_evt(timer_evt), .pina_evt(pina_evt),
  .pinb_evt(pinb_evt), .legacy_req(legacy_req), .cpu_id(cpu_id),
  .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse), .ext_pulse(ext_pulse),
  .req_vec(req_vec), .trig_vec(trig_vec));

// File: tb/lvec_dispatch_bench.sv
module lvec_dispatch_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, wr_en, wr_mask, wr_level, timer_evt, pina_evt, pinb_evt, legacy_req, glob_en;
  logic [2:0]   wr_addr, wr_mode;
  logic [7:0]   wr_vector, cpu_id;
  logic         smi_pulse, nmi_pulse, ext_pulse;
  logic [255:0] req_vec, trig_vec;

  lvec_dispatch u_lvec_dispatch (.*);

  logic         m_mask [3];
  logic         m_lvl  [3];
  logic [2:0]   m_mode [3];
  logic [7:0]   m_vec  [3];
  logic [255:0] m_req, m_trig;
  logic         m_smi, m_nmi, m_ext;
  int errs = 0, checks = 0;
  bit done = 0;

  function automatic logic [2:0] addr_of(int s);
    return (s == 0) ? 3'd0 : (s == 1) ? 3'd3 : 3'd4;
  endfunction

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin
      m_mask[s] = 1'b1; m_lvl[s] = 1'b0; m_mode[s] = 3'b000; m_vec[s] = 8'h00;
    end
    m_req = '0; m_trig = '0; m_smi = 0; m_nmi = 0; m_ext = 0;
  endtask

  // one cycle: inputs driven after a falling edge, outputs checked at the next one
  task automatic cyc(string tag, logic t, logic pa, logic pb, logic lg, logic [7:0] id, logic ge,
                     logic we, logic [2:0] wa, logic wm, logic wl, logic [2:0] wmd, logic [7:0] wv);
    logic [2:0] ev;
    logic [255:0] setm, lvlm;
    timer_evt = t; pina_evt = pa; pinb_evt = pb; legacy_req = lg; cpu_id = id; glob_en = ge;
    wr_en = we; wr_addr = wa; wr_mask = wm; wr_level = wl; wr_mode = wmd; wr_vector = wv;
    ev = {pb, pa | (lg && id == 8'd0 && (!ge || !m_mask[1])), t};
    m_smi = 0; m_nmi = 0; m_ext = 0; setm = '0; lvlm = '0;
    for (int s = 0; s < 3; s++) begin
      if (ev[s] && !m_mask[s]) begin
        if (m_mode[s] == 3'b010) m_smi = 1;
        else if (m_mode[s] == 3'b100) m_nmi = 1;
        else if (m_mode[s] == 3'b111) m_ext = 1;
        else if (m_mode[s] == 3'b000) begin
          setm[m_vec[s]] = 1'b1;
          if (s != 0 && m_lvl[s]) lvlm[m_vec[s]] = 1'b1;
        end
      end
    end
    m_req = m_req | setm;
    m_trig = (m_trig & ~setm) | lvlm;
    for (int s = 0; s < 3; s++) begin
      if (we && wa == addr_of(s)) begin
        m_mask[s] = wm; m_lvl[s] = wl; m_mode[s] = wmd; m_vec[s] = wv;
      end
    end
    @(negedge clk);
    chk(tag, "smi", {255'd0, smi_pulse}, {255'd0, m_smi});
    chk(tag, "nmi", {255'd0, nmi_pulse}, {255'd0, m_nmi});
    chk(tag, "ext", {255'd0, ext_pulse}, {255'd0, m_ext});
    chk(tag, "req", req_vec, m_req);
    chk(tag, "trig", trig_vec, m_trig);
  endtask

  task automatic wr(string tag, logic [2:0] a, logic m, logic l, logic [2:0] md, logic [7:0] v);
    cyc(tag, 0, 0, 0, 0, 8'd0, 1, 1, a, m, l, md, v);
  endtask

  task automatic ev(string tag, logic t, logic pa, logic pb);
    cyc(tag, t, pa, pb, 0, 8'd0, 1, 0, 3'd0, 0, 0, 3'd0, 8'd0);
  endtask

  task automatic leg(string tag, logic [7:0] id, logic ge);
    cyc(tag, 0, 0, 0, 1, id, ge, 0, 3'd0, 0, 0, 3'd0, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0;
    timer_evt = 0; pina_evt = 0; pinb_evt = 0; legacy_req = 0; cpu_id = 0; glob_en = 1;
    wr_en = 0; wr_addr = 0; wr_mask = 0; wr_level = 0; wr_mode = 0; wr_vector = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "req after reset", req_vec, '0);
    chk("R1", "trig after reset", trig_vec, '0);
    chk("R1", "pulses after reset", {253'd0, smi_pulse, nmi_pulse, ext_pulse}, '0);
    ev("R1", 1, 1, 1);                     // entries masked out of reset
    leg("R1", 8'd0, 1);

    wr("R5", 3'd0, 0, 0, 3'b000, 8'h20);
    ev("R5", 1, 0, 0);
    wr("R6", 3'd0, 0, 1, 3'b000, 8'h21);   // level flag on timer is not honoured
    ev("R6", 1, 0, 0);
    wr("R6", 3'd3, 0, 1, 3'b000, 8'h40);
    ev("R6", 0, 1, 0);
    wr("R6", 3'd4, 0, 0, 3'b000, 8'h40);
    ev("R6", 0, 0, 1);                      // edge delivery clears the level bit

    wr("R3", 3'd0, 1, 0, 3'b010, 8'h00);
    ev("R3", 1, 0, 0);
    wr("R4", 3'd3, 0, 0, 3'b010, 8'h00);
    ev("R4", 0, 1, 0);
    ev("R4", 0, 0, 0);                      // pulse lasts one cycle
    wr("R4", 3'd4, 0, 0, 3'b100, 8'h00);
    ev("R4", 0, 0, 1);
    wr("R4", 3'd0, 0, 0, 3'b111, 8'h00);
    ev("R4", 1, 0, 0);
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 3 || m == 5 || m == 6) begin
        wr("R7", 3'd4, 0, 1, 3'(m), 8'h77);
        ev("R7", 0, 0, 1);
      end
    end

    wr("R2", 3'd1, 0, 0, 3'b000, 8'h55);   // unused addresses
    wr("R2", 3'd5, 0, 0, 3'b000, 8'h56);
    wr("R2", 3'd7, 0, 0, 3'b000, 8'h57);
    ev("R2", 1, 1, 1);
    cyc("R2", 1, 0, 0, 0, 8'd0, 1, 1, 3'd0, 0, 0, 3'b000, 8'h90); // event sees old ExtINT entry
    ev("R2", 1, 0, 0);

    wr("R8", 3'd3, 0, 0, 3'b111, 8'h00);
    leg("R8", 8'd0, 1);
    leg("R8", 8'd1, 1);
    leg("R8", 8'd0, 0);
    wr("R8", 3'd3, 1, 0, 3'b111, 8'h00);
    leg("R8", 8'd0, 0);
    leg("R8", 8'd0, 1);

    wr("R9", 3'd0, 0, 0, 3'b000, 8'hA0);
    wr("R9", 3'd3, 0, 1, 3'b000, 8'hA0);
    wr("R9", 3'd4, 0, 0, 3'b000, 8'hA0);
    ev("R9", 1, 1, 1);
    wr("R9", 3'd0, 0, 0, 3'b010, 8'h00);
    wr("R9", 3'd3, 0, 0, 3'b100, 8'h00);
    wr("R9", 3'd4, 0, 0, 3'b111, 8'h00);
    ev("R9", 1, 1, 1);
    ev("R10", 0, 0, 0);
    ev("R10", 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      int pick;
      pick = $urandom_range(0, 7);
      a = (pick < 3) ? 3'd0 : (pick < 5) ? 3'd3 : (pick < 7) ? 3'd4 : 3'($urandom);
      cyc("R9", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'd0, 1'($urandom),
          1'($urandom), a, ($urandom_range(0, 3) == 0), 1'($urandom),
          3'($urandom), 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule